// File: doc/BRIEF.md
# Tagged Translation Look-Aside Buffer with Access Checking

This block caches virtual-to-physical page translations for a 32-bit address space with 4 KiB pages. Every entry is compared with the incoming virtual page number at the same time, so any entry can hold any page. Each lookup carries the current address-space identifier, the privilege mode and the kind of access. One clock later the block reports one of four results: a granted hit with the physical address, a miss, a not-present fault, or a protection fault.

Entries carry an address-space tag, so a process switch does not need a flush. Entries marked global match under every identifier and hold the shared kernel half of the address space. The block never walks page tables itself. On a miss it raises a refill request with the missing page number, and an external handler writes the translation back through the refill port. Software can invalidate all entries of one identifier before that identifier is reused, or can clear the whole buffer.

Top module: `tagged_tlb`

## Requirements
- R1: A synchronous active-high reset invalidates every entry, clears the result-valid and refill-request outputs, and sets the replacement pointer to index 0.
- R2: A lookup accepted in cycle t is reported in cycle t+1 with res_valid high. A granted hit gives res_status 0 and res_paddr equal to the entry's 20-bit physical page number followed by the untouched low 12 bits of the virtual address.
- R3: A non-global entry matches only when its stored identifier equals the lookup identifier. A global entry matches under any identifier. At most one entry matches any lookup.
- R4: A lookup that matches no entry gives res_status 1. In the same cycle refill_req is high and refill_vpn carries bits 31:12 of the missed address. refill_req is low at all other times.
- R5: A matching entry whose present bit is clear gives res_status 2. This holds whatever the access type and mode.
- R6: A matching, present entry gives res_status 3 when the access type is not allowed. Access codes are 0 read, 1 write, 2 execute and 3 reserved, and each is checked against the entry's read, write or execute bit; the reserved code is always denied. The same status results when user mode (lk_user=1) reaches an entry whose user bit is clear. Kernel mode ignores the user bit and has the same rights as user mode otherwise.
- R7: A user-mode lookup whose address has bits 31:30 both set gives res_status 3 on a present matching entry, even if that entry's user bit is set.
- R8: A flush by identifier invalidates every non-global entry holding that identifier. Global entries and entries of other identifiers survive.
- R9: A full flush invalidates every entry, global ones included.
- R10: When a refill, a flush by identifier or a full flush is asserted in the same cycle as a lookup, the lookup is dropped (res_valid low the next cycle). When several commands coincide, only one acts: full flush first, then flush by identifier, then refill.
- R11: A refill is placed in the lowest-numbered invalid entry. When no entry is invalid, it goes to the entry at the replacement pointer. The pointer advances by one, wrapping at the entry count, on every refill.
- R12: A refill whose page number equals that of a valid entry that could match with it (same identifier, or either one global) overwrites the lowest such entry and invalidates any other such entry, so no lookup ever sees two matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| res_valid | output | 1 | Result of the previous cycle's lookup is present |
| res_status | output | 2 | 0 hit, 1 miss, 2 not present, 3 protection fault |
| res_paddr | output | 32 | Physical address on a granted hit, zero otherwise |
| refill_req | output | 1 | Miss reported; handler should supply an entry |
| refill_vpn | output | 20 | Virtual page number that missed |
| wr_en | input | 1 | Refill write strobe |
| wr_vpn | input | 20 | Refill virtual page number |
| wr_ppn | input | 20 | Refill physical page number |
| wr_asid | input | 8 | Refill identifier |
| wr_global | input | 1 | Refill entry matches under any identifier |
| wr_present | input | 1 | Refill page is resident |
| wr_read | input | 1 | Refill read permission |
| wr_write | input | 1 | Refill write permission |
| wr_exec | input | 1 | Refill execute permission |
| wr_user | input | 1 | Refill page reachable from user mode |
| fl_asid_en | input | 1 | Flush entries of one identifier |
| fl_asid | input | 8 | Identifier to flush |
| fl_all | input | 1 | Flush every entry |

## Verification
The hardest state to reach from the ports is a full buffer, where placement falls back to the rotating pointer. It is just as hard to reach the case where several entries share one page number under different identifiers and a global refill must fold them into one. The bench resets, writes exactly one refill per slot so the pointer wraps to index 0, and then shows that the next refill evicts slot 0. It also writes the same page under two identifiers and then as global, and checks that the lookup sees only the new translation. A long random run then mixes refills, both flush kinds and lookups over a small page pool containing kernel pages. A bench model follows every step, and its placement and status rules are written from the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int PG_BITS = 12;
    localparam int VPN_W   = VA_W - PG_BITS;
    localparam int PPN_W   = 20;
    localparam int ASID_W  = 8;

    typedef enum logic [1:0] {
        ST_HIT     = 2'd0,
        ST_MISS    = 2'd1,
        ST_NOTPRES = 2'd2,
        ST_PROT    = 2'd3
    } tlb_status_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } tlb_acc_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glb;
        logic              present;
        logic              rd;
        logic              wr;
        logic              ex;
        logic              usr;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [N-1:0]      e_valid,
    input  logic [N-1:0]      e_glb,
    input  logic [VPN_W-1:0]  e_vpn  [N],
    input  logic [ASID_W-1:0] e_asid [N],
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glb,
    output logic [N-1:0]      hit_vec,
    output logic [N-1:0]      dup_vec,
    output logic [N-1:0]      inv_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = e_valid[g] && (e_vpn[g] == lk_vpn)
                          && (e_glb[g] || (e_asid[g] == lk_asid));
        assign dup_vec[g] = e_valid[g] && (e_vpn[g] == wr_vpn)
                          && (e_glb[g] || wr_glb || (e_asid[g] == wr_asid));
        assign inv_vec[g] = !e_valid[g];
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     dup_vec,
    input  logic [N-1:0]     inv_vec,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] wr_idx
);
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] inv_idx;

    always_comb begin
        dup_idx = '0;
        inv_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (dup_vec[i]) dup_idx = IDX_W'(i);
            if (inv_vec[i]) inv_idx = IDX_W'(i);
        end
        if (|dup_vec)      wr_idx = dup_idx;
        else if (|inv_vec) wr_idx = inv_idx;
        else               wr_idx = rr_ptr;
    end
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_user,
    input  logic [1:0]        lk_acc,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [VA_W-1:0]   res_paddr,
    output logic              refill_req,
    output logic [VPN_W-1:0]  refill_vpn,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              wr_present,
    input  logic              wr_read,
    input  logic              wr_write,
    input  logic              wr_exec,
    input  logic              wr_user,
    input  logic              fl_asid_en,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_all
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);

    typedef struct packed {
        tlb_entry_t [NUM_ENTRIES-1:0] ents;
        logic [IDX_W-1:0]             rr;
        logic                         res_v;
        tlb_status_e                  st;
        logic [VA_W-1:0]              pa;
        logic [VPN_W-1:0]             mvpn;
    } tlb_state_t;

    tlb_state_t q, d;

    logic [NUM_ENTRIES-1:0] e_valid, e_glb;
    logic [VPN_W-1:0]       e_vpn  [NUM_ENTRIES];
    logic [ASID_W-1:0]      e_asid [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hit_vec, dup_vec, inv_vec;
    logic [IDX_W-1:0]       wr_idx;
    logic [VPN_W-1:0]       lk_vpn;

    assign lk_vpn = lk_vaddr[VA_W-1:PG_BITS];

    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            e_valid[i] = q.ents[i].valid;
            e_glb[i]   = q.ents[i].glb;
            e_vpn[i]   = q.ents[i].vpn;
            e_asid[i]  = q.ents[i].asid;
        end
    end

    tlb_match #(.N(NUM_ENTRIES)) i_match (
        .e_valid (e_valid),
        .e_glb   (e_glb),
        .e_vpn   (e_vpn),
        .e_asid  (e_asid),
        .lk_vpn  (lk_vpn),
        .lk_asid (lk_asid),
        .wr_vpn  (wr_vpn),
        .wr_asid (wr_asid),
        .wr_glb  (wr_global),
        .hit_vec (hit_vec),
        .dup_vec (dup_vec),
        .inv_vec (inv_vec)
    );

    tlb_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) i_pick (
        .dup_vec (dup_vec),
        .inv_vec (inv_vec),
        .rr_ptr  (q.rr),
        .wr_idx  (wr_idx)
    );

    tlb_entry_t sel;
    tlb_entry_t new_ent;
    logic       any_cmd;
    logic       perm_ok;
    logic       kern_page;

    always_comb begin
        d       = q;
        any_cmd = wr_en || fl_asid_en || fl_all;

        // gather the single matching entry
        sel = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (hit_vec[i]) sel = tlb_entry_t'(sel | q.ents[i]);
        end

        kern_page = (lk_vpn[VPN_W-1 -: 2] == 2'b11);
        unique case (tlb_acc_e'(lk_acc))
            ACC_READ:  perm_ok = sel.rd;
            ACC_WRITE: perm_ok = sel.wr;
            ACC_EXEC:  perm_ok = sel.ex;
            default:   perm_ok = 1'b0;
        endcase
        if (lk_user && (!sel.usr || kern_page)) perm_ok = 1'b0;

        d.res_v = lk_valid && !any_cmd;
        d.mvpn  = lk_vpn;
        d.pa    = '0;
        if (!(|hit_vec))       d.st = ST_MISS;
        else if (!sel.present) d.st = ST_NOTPRES;
        else if (!perm_ok)     d.st = ST_PROT;
        else begin
            d.st = ST_HIT;
            d.pa = {sel.ppn, lk_vaddr[PG_BITS-1:0]};
        end

        new_ent = '{valid: 1'b1, vpn: wr_vpn, asid: wr_asid, glb: wr_global,
                    present: wr_present, rd: wr_read, wr: wr_write,
                    ex: wr_exec, usr: wr_user, ppn: wr_ppn};

        if (fl_all) begin
            for (int i = 0; i < NUM_ENTRIES; i++) d.ents[i].valid = 1'b0;
        end else if (fl_asid_en) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (!q.ents[i].glb && (q.ents[i].asid == fl_asid))
                    d.ents[i].valid = 1'b0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (dup_vec[i]) d.ents[i].valid = 1'b0;
            end
            d.ents[wr_idx] = new_ent;
            d.rr = (q.rr == IDX_W'(NUM_ENTRIES - 1)) ? '0 : q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign res_valid  = q.res_v;
    assign res_status = q.st;
    assign res_paddr  = q.res_v ? q.pa : '0;
    assign refill_req = q.res_v && (q.st == ST_MISS);
    assign refill_vpn = q.mvpn;
endmodule

// File: rtl/tagged_tlb_checker.sv
module tagged_tlb_checker #(
    parameter int N = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         lk_valid,
    input logic [31:0]  lk_vaddr,
    input logic         lk_user,
    input logic         wr_en,
    input logic         fl_asid_en,
    input logic         fl_all,
    input logic         res_valid,
    input logic [1:0]   res_status,
    input logic [31:0]  res_paddr,
    input logic         refill_req,
    input logic [N-1:0] hit_vec
);
    logic cmd;
    assign cmd = wr_en || fl_asid_en || fl_all;

    // R3: never two matching entries
    a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R2: accepted lookup reported next cycle
    a_r2_result_next: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !cmd) |=> res_valid);

    // R2: offset passes through on a hit
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !cmd) |=> (res_status != 2'd0 ||
                                res_paddr[11:0] == $past(lk_vaddr[11:0])));

    // R10: a lookup alongside any command is dropped
    a_r10_cmd_drops: assert property (@(posedge clk) disable iff (rst)
        cmd |=> !res_valid);

    // R4: refill request exactly on reported misses
    a_r4_req_on_miss: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_status == 2'd1) |-> refill_req);
    a_r4_req_only_miss: assert property (@(posedge clk) disable iff (rst)
        refill_req |-> (res_valid && res_status == 2'd1));

    // R7: user mode never granted in the kernel region
    a_r7_kernel_deny: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !cmd && lk_user && lk_vaddr[31:30] == 2'b11)
        |=> (res_status != 2'd0));

    // R9: nothing survives a full flush
    a_r9_flush_all: assert property (@(posedge clk) disable iff (rst)
        (fl_all ##1 (lk_valid && !cmd)) |=> (res_status == 2'd1));
endmodule

bind tagged_tlb tagged_tlb_checker #(.N(NUM_ENTRIES)) i_tagged_tlb_checker (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_user    (lk_user),
    .wr_en      (wr_en),
    .fl_asid_en (fl_asid_en),
    .fl_all     (fl_all),
    .res_valid  (res_valid),
    .res_status (res_status),
    .res_paddr  (res_paddr),
    .refill_req (refill_req),
    .hit_vec    (hit_vec)
);

// File: tb/test_tagged_tlb.sv
module test_tagged_tlb;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_user = 0;
    logic [1:0]  lk_acc = '0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [31:0] res_paddr;
    logic        refill_req;
    logic [19:0] refill_vpn;
    logic        wr_en = 0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 0, wr_present = 0, wr_read = 0, wr_write = 0;
    logic        wr_exec = 0, wr_user = 0;
    logic        fl_asid_en = 0;
    logic [7:0]  fl_asid = '0;
    logic        fl_all = 0;

    always #10 clk = ~clk;

    tagged_tlb #(.NUM_ENTRIES(N)) i_tagged_tlb (.*);

    // reference model
    bit          mv [N];
    logic [19:0] mvpn [N];
    logic [7:0]  masid [N];
    bit          mg [N], mp [N], mr [N], mw [N], mx [N], mu [N];
    logic [19:0] mppn [N];
    int          mptr;
    int          checks = 0, fails = 0;
    bit          done = 0;

    task automatic chk(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void m_reset();
        for (int i = 0; i < N; i++) mv[i] = 0;
        mptr = 0;
    endfunction

    function automatic void m_look(input logic [19:0] vpn, input logic [7:0] asid,
                                   input bit usr, input logic [1:0] acc,
                                   output logic [1:0] st, output logic [19:0] ppn);
        int idx = -1;
        bit ok;
        for (int i = 0; i < N; i++)
            if (mv[i] && mvpn[i] == vpn && (mg[i] || masid[i] == asid)) idx = i;
        ppn = '0;
        if (idx < 0) st = 2'd1;
        else if (!mp[idx]) st = 2'd2;
        else begin
            ok = (acc == 0) ? mr[idx] : (acc == 1) ? mw[idx] : (acc == 2) ? mx[idx] : 1'b0;
            if (usr && (!mu[idx] || vpn[19:18] == 2'b11)) ok = 0;
            st = ok ? 2'd0 : 2'd3;
            ppn = mppn[idx];
        end
    endfunction

    function automatic void m_apply();
        int tgt = -1, inv = -1;
        if (fl_all) begin
            for (int i = 0; i < N; i++) mv[i] = 0;
        end else if (fl_asid_en) begin
            for (int i = 0; i < N; i++) if (!mg[i] && masid[i] == fl_asid) mv[i] = 0;
        end else if (wr_en) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (!mv[i]) inv = i;
                if (mv[i] && mvpn[i] == wr_vpn && (mg[i] || wr_global || masid[i] == wr_asid)) begin
                    if (tgt >= 0) mv[tgt] = 0;
                    tgt = i;
                end
            end
            if (tgt < 0) tgt = (inv >= 0) ? inv : mptr;
            mv[tgt] = 1; mvpn[tgt] = wr_vpn; masid[tgt] = wr_asid; mg[tgt] = wr_global;
            mp[tgt] = wr_present; mr[tgt] = wr_read; mw[tgt] = wr_write;
            mx[tgt] = wr_exec; mu[tgt] = wr_user; mppn[tgt] = wr_ppn;
            mptr = (mptr + 1) % N;
        end
    endfunction

    task automatic idle();
        lk_valid = 0; wr_en = 0; fl_asid_en = 0; fl_all = 0;
    endtask

    task automatic look(logic [19:0] vpn, logic [7:0] asid, bit usr, logic [1:0] acc,
                        logic [11:0] off);
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_asid = asid; lk_user = usr; lk_acc = acc;
    endtask

    task automatic refill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] ppn, bit g,
                          bit p, bit r, bit w, bit x, bit u);
        wr_en = 1; wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn; wr_global = g;
        wr_present = p; wr_read = r; wr_write = w; wr_exec = x; wr_user = u;
    endtask

    // one clock: predict, advance, update model, compare
    task automatic step(string tag);
        bit          ev;
        logic [1:0]  est;
        logic [19:0] eppn;
        ev = lk_valid && !(wr_en || fl_asid_en || fl_all);
        m_look(lk_vaddr[31:12], lk_asid, lk_user, lk_acc, est, eppn);
        @(posedge clk);
        #1;
        m_apply();
        chk({tag, " valid"}, res_valid == ev, 32'(res_valid), 32'(ev));
        if (ev) begin
            chk({tag, " status"}, res_status == est, 32'(res_status), 32'(est));
            if (est == 2'd0)
                chk({tag, " paddr"}, res_paddr == {eppn, lk_vaddr[11:0]}, res_paddr,
                    {eppn, lk_vaddr[11:0]});
            chk({tag, " refill_req"}, refill_req == (est == 2'd1), 32'(refill_req),
                32'(est == 2'd1));
            if (est == 2'd1)
                chk({tag, " refill_vpn"}, refill_vpn == lk_vaddr[31:12], 32'(refill_vpn),
                    32'(lk_vaddr[31:12]));
        end else begin
            chk({tag, " no req"}, refill_req == 1'b0, 32'(refill_req), 32'd0);
        end
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        repeat (2) @(posedge clk);
        #1;
        m_reset();
        chk("R1 res_valid after reset", res_valid == 0, 32'(res_valid), 32'd0);
        chk("R1 refill_req after reset", refill_req == 0, 32'(refill_req), 32'd0);
        rst = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20081015));
        do_reset();

        look(20'h00400, 8'd1, 1, 2'd0, 12'h3ab); step("R1 empty");

        // R2 basic hit
        refill(20'h00400, 8'd1, 20'h12345, 0, 1, 1, 1, 0, 1); step("R11 place");
        look(20'h00400, 8'd1, 1, 2'd0, 12'habc); step("R2 hit");
        chk("R2 literal paddr", res_paddr == 32'h12345abc, res_paddr, 32'h12345abc);

        // R3 identifier tag and global entries
        look(20'h00400, 8'd2, 1, 2'd0, 12'h001); step("R3 other asid");
        chk("R3 literal miss", res_status == 2'd1, 32'(res_status), 32'd1);
        refill(20'hC0010, 8'd7, 20'h00777, 1, 1, 1, 0, 1, 1); step("R3 global place");
        look(20'hC0010, 8'd3, 0, 2'd2, 12'h010); step("R3 global hit");
        chk("R3 literal global", res_status == 2'd0, 32'(res_status), 32'd0);

        // R7 kernel region denied to user even with user bit
        look(20'hC0010, 8'd3, 1, 2'd0, 12'h020); step("R7 user kernel");
        chk("R7 literal prot", res_status == 2'd3, 32'(res_status), 32'd3);

        // R4 miss reporting
        look(20'h00999, 8'd1, 0, 2'd0, 12'h000); step("R4 miss");
        chk("R4 literal vpn", refill_vpn == 20'h00999, 32'(refill_vpn), 32'h00999);

        // R5 not present wins over permissions
        refill(20'h00500, 8'd1, 20'h00055, 0, 0, 0, 0, 0, 0); step("R5 place");
        look(20'h00500, 8'd1, 1, 2'd3, 12'h000); step("R5 not present");
        chk("R5 literal", res_status == 2'd2, 32'(res_status), 32'd2);

        // R6 permission matrix
        look(20'h00400, 8'd1, 1, 2'd1, 12'h004); step("R6 user write ok");
        look(20'h00400, 8'd1, 1, 2'd2, 12'h004); step("R6 no exec");
        refill(20'h00600, 8'd1, 20'h00066, 0, 1, 1, 0, 0, 0); step("R6 place");
        look(20'h00600, 8'd1, 1, 2'd0, 12'h000); step("R6 user blocked");
        chk("R6 literal user prot", res_status == 2'd3, 32'(res_status), 32'd3);
        look(20'h00600, 8'd1, 0, 2'd0, 12'h000); step("R6 kernel read");
        look(20'h00600, 8'd1, 0, 2'd1, 12'h000); step("R6 kernel write");
        look(20'h00400, 8'd1, 0, 2'd3, 12'h000); step("R6 reserved access");

        // R10 commands drop a same-cycle lookup
        look(20'h00400, 8'd1, 1, 2'd0, 12'h000);
        refill(20'h00800, 8'd1, 20'h00088, 0, 1, 1, 1, 1, 1); step("R10 refill drop");
        chk("R10 literal", res_valid == 0, 32'(res_valid), 32'd0);
        look(20'h00400, 8'd1, 1, 2'd0, 12'h000); fl_asid_en = 1; fl_asid = 8'd9;
        step("R10 flush drop");
        fl_all = 1; fl_asid_en = 1; fl_asid = 8'd1; refill(20'h00900, 8'd1, 20'h1, 0, 1, 1, 1, 1, 1);
        step("R10 priority");
        look(20'hC0010, 8'd1, 0, 2'd0, 12'h000); step("R10 all won");
        refill(20'h00400, 8'd1, 20'h12345, 0, 1, 1, 1, 0, 1); step("R10 restore");
        refill(20'hC0010, 8'd7, 20'h00777, 1, 1, 1, 0, 1, 1); step("R10 restore");

        // R8 flush by identifier keeps globals
        fl_asid_en = 1; fl_asid = 8'd1; step("R8 flush");
        look(20'h00400, 8'd1, 1, 2'd0, 12'h000); step("R8 gone");
        chk("R8 literal", res_status == 2'd1, 32'(res_status), 32'd1);
        look(20'hC0010, 8'd1, 0, 2'd0, 12'h000); step("R8 global kept");

        // R9 full flush
        fl_all = 1; step("R9 flush");
        look(20'hC0010, 8'd1, 0, 2'd0, 12'h000); step("R9 gone");

        // R12 overwrite in place
        refill(20'h00700, 8'd1, 20'h00011, 0, 1, 1, 1, 1, 1); step("R12 a");
        refill(20'h00700, 8'd2, 20'h00022, 0, 1, 1, 1, 1, 1); step("R12 b");
        refill(20'h00700, 8'd5, 20'h00033, 1, 1, 1, 1, 1, 1); step("R12 global");
        look(20'h00700, 8'd1, 0, 2'd0, 12'h123); step("R12 merged");
        chk("R12 literal", res_paddr == 32'h00033123, res_paddr, 32'h00033123);

        // R11 round-robin after a full table
        do_reset();
        for (int i = 0; i < N; i++) begin
            refill(20'(i), 8'd0, 20'(i + 1), 0, 1, 1, 1, 1, 1); step("R11 fill");
        end
        refill(20'h00100, 8'd0, 20'h0abcd, 0, 1, 1, 1, 1, 1); step("R11 evict");
        look(20'h00000, 8'd0, 0, 2'd0, 12'h000); step("R11 victim");
        chk("R11 literal victim", res_status == 2'd1, 32'(res_status), 32'd1);
        look(20'h00001, 8'd0, 0, 2'd0, 12'h000); step("R11 neighbour");
        look(20'h00100, 8'd0, 0, 2'd0, 12'h000); step("R11 new");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int          r = $urandom % 100;
            int          k = $urandom % 12;
            logic [19:0] vpn = (k < 8) ? 20'h00010 + 20'(k) : 20'hC0000 + 20'(k);
            if ($urandom % 100 < 80)
                look(vpn, 8'($urandom % 4), 1'($urandom), 2'($urandom), 12'($urandom));
            if (r < 10) begin
                logic [19:0] wv = ($urandom % 12 < 8) ? 20'h00010 + 20'($urandom % 8)
                                                      : 20'hC0008 + 20'($urandom % 4);
                refill(wv, 8'($urandom % 4), 20'($urandom),
                       (wv[19:18] == 2'b11) || ($urandom % 8 == 0),
                       ($urandom % 100) < 85, 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom));
            end else if (r < 12) begin
                fl_asid_en = 1; fl_asid = 8'($urandom % 4);
            end else if (r < 13) begin
                fl_all = 1;
            end
            step("R2/R4/R5/R6 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule